// File: doc/BRIEF.md
# Decimating Filter Mode Control Registers

This block holds the host-programmable controls of a two-stage decimating filter. A front-end integrate-and-decimate stage feeds a FIR stage. The host writes one word per cycle and picks the target register with a 2-bit select. The block stores the front-end decimation rate, the front-end stage count and bit growth, and the FIR mode bits. It then drives the effective control values that the filter datapath uses.

Three mode bits have side effects, and the block applies them here:
- **Bypass.** Front-end bypass replaces the stored rate, stage count and growth with fixed values. It also marks the stage/growth register as stale until the host rewrites that register with bypass off.
- **Disable.** FIR disable emits a one-cycle abort pulse that ends the running FIR cycle. The bit clears itself when any start input is raised.
- **Clear-accumulator.** FIR clear-accumulator zeroes the MAC feedback path and forces the data-ready indication low.

A register write takes effect on the clock edge that samples it. The host reset is asynchronous and its release is synchronised inside the block.

Top module: `ddf_mode_ctrl`

## Requirements
- R1: After reset every output is 0: the rates, stages, growth, bypass, stale, disable, abort, clear-accumulator and data-ready outputs.
- R2: A write with select 2'b10 stores `wr_data[9:0]` as the rate code, which is the decimation minus one, and stores `wr_data[10]` as bypass. With bypass 0, `eff_rate` shows the code from the next cycle on.
- R3: While bypass is 1, `eff_rate` and `eff_stages` are 0 and `eff_growth` is 50, whatever values are stored.
- R4: A write with select 2'b11 stores `wr_data[2:0]` as the stage count and `wr_data[8:3]` as the growth. These show on `eff_stages` and `eff_growth` while bypass is 0.
- R5: `front_stale` goes to 1 when a select 2'b10 write sets bypass. It clears only on a select 2'b11 write made while the stored bypass is 0.
- R6: A write with select 2'b01 stores `wr_data[0]` as FIR disable and `wr_data[1]` as clear-accumulator. Writing 0 to bit 0 clears disable.
- R7: When any bit of `start_in` is 1, disable is 0 in the next cycle. This holds even if the same cycle carries a write that sets disable.
- R8: `fir_abort` is high for exactly the one cycle in which `fir_disable` first reads 1 after having been 0.
- R9: While clear-accumulator is 1, `acc_fb_zero` is 1 and `data_rdy_out` is 0. Otherwise `data_rdy_out` follows `data_rdy_in` in the same cycle.
- R10: A cycle with `wr_en` low, or with select 2'b00, changes no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 11 | Host write data |
| start_in | input | 2 | Start inputs; any high clears FIR disable |
| data_rdy_in | input | 1 | Raw data-ready from the FIR datapath |
| eff_rate | output | 10 | Effective front-end rate code |
| eff_stages | output | 3 | Effective front-end stage count |
| eff_growth | output | 6 | Effective front-end bit growth |
| front_bypass | output | 1 | Front-end bypass active |
| front_stale | output | 1 | Stage/growth register needs rewriting |
| fir_disable | output | 1 | FIR disabled |
| fir_abort | output | 1 | One-cycle pulse ending the current FIR cycle |
| acc_fb_zero | output | 1 | Zero the MAC feedback path |
| data_rdy_out | output | 1 | Gated data-ready |

## Verification
A host write that sets FIR disable can land in the same cycle as a start pulse that clears it. Both the rule that start wins and the abort pulse are decided in that one cycle. The bench sweeps every combination of prior disable state, the two write bits and the start pattern. It compares disable, abort and clear-accumulator against a model that applies the write first and the start override after it. A set disable with no start must produce exactly one abort cycle. A set that collides with a start must produce none.

// File: rtl/ddf_mode_pkg.sv
package ddf_mode_pkg;
  parameter int RATE_W     = 10;
  parameter int STG_W      = 3;
  parameter int GROW_W     = 6;
  parameter int NUM_START  = 2;
  parameter int BYP_GROWTH = 50;

  localparam int BYP_BIT = RATE_W;
  localparam int CFG_W   = BYP_BIT + 1;
  localparam int STG_LSB = 0;
  localparam int GRW_LSB = STG_LSB + STG_W;
  localparam int DIS_BIT = 0;
  localparam int CLA_BIT = 1;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'b00,
    SEL_FIR    = 2'b01,
    SEL_FRONT1 = 2'b10,
    SEL_FRONT2 = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic fir;
    logic front1;
    logic front2;
  } wr_strobe_t;
endpackage

// File: rtl/ddf_rst_sync.sv
module ddf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ddf_wr_decode.sv
module ddf_wr_decode
  import ddf_mode_pkg::*;
(
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  output wr_strobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_FIR:    strobe.fir    = 1'b1;
        SEL_FRONT1: strobe.front1 = 1'b1;
        SEL_FRONT2: strobe.front2 = 1'b1;
        default:    strobe        = '0;
      endcase
    end
  end
endmodule

// File: rtl/ddf_front_regs.sv
module ddf_front_regs
  import ddf_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_front1,
  input  logic              wr_front2,
  input  logic [RATE_W-1:0] rate_in,
  input  logic              byp_in,
  input  logic [STG_W-1:0]  stg_in,
  input  logic [GROW_W-1:0] grow_in,
  output logic [RATE_W-1:0] eff_rate,
  output logic [STG_W-1:0]  eff_stages,
  output logic [GROW_W-1:0] eff_growth,
  output logic              bypass,
  output logic              stale
);
  localparam logic [GROW_W-1:0] GROW_FIXED = GROW_W'(BYP_GROWTH);

  logic [RATE_W-1:0] rate_q, rate_d;
  logic [STG_W-1:0]  stg_q,  stg_d;
  logic [GROW_W-1:0] grow_q, grow_d;
  logic              byp_q,  byp_d;
  logic              stale_q, stale_d;

  always_comb begin
    rate_d  = rate_q;
    byp_d   = byp_q;
    stg_d   = stg_q;
    grow_d  = grow_q;
    stale_d = stale_q;
    if (wr_front1) begin
      rate_d = rate_in;
      byp_d  = byp_in;
      if (byp_in) stale_d = 1'b1;
    end
    if (wr_front2) begin
      stg_d  = stg_in;
      grow_d = grow_in;
      if (!byp_q) stale_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      byp_q   <= 1'b0;
      stg_q   <= '0;
      grow_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      rate_q  <= rate_d;
      byp_q   <= byp_d;
      stg_q   <= stg_d;
      grow_q  <= grow_d;
      stale_q <= stale_d;
    end
  end

  always_comb begin
    if (byp_q) begin
      eff_rate   = '0;
      eff_stages = '0;
      eff_growth = GROW_FIXED;
    end else begin
      eff_rate   = rate_q;
      eff_stages = stg_q;
      eff_growth = grow_q;
    end
  end

  assign bypass = byp_q;
  assign stale  = stale_q;
endmodule

// File: rtl/ddf_fir_mode.sv
module ddf_fir_mode
  import ddf_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fir,
  input  logic                 dis_in,
  input  logic                 cla_in,
  input  logic [NUM_START-1:0] start_in,
  input  logic                 rdy_in,
  output logic                 disable_o,
  output logic                 abort_o,
  output logic                 acc_zero_o,
  output logic                 rdy_out
);
  logic dis_q, dis_d;
  logic cla_q, cla_d;
  logic abt_q, abt_d;
  logic any_start;

  always_comb begin
    any_start = |start_in;
    dis_d = dis_q;
    cla_d = cla_q;
    if (wr_fir) begin
      dis_d = dis_in;
      cla_d = cla_in;
    end
    if (any_start) dis_d = 1'b0;
    abt_d = dis_d & ~dis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b0;
      cla_q <= 1'b0;
      abt_q <= 1'b0;
    end else begin
      dis_q <= dis_d;
      cla_q <= cla_d;
      abt_q <= abt_d;
    end
  end

  assign disable_o  = dis_q;
  assign abort_o    = abt_q;
  assign acc_zero_o = cla_q;
  assign rdy_out    = rdy_in & ~cla_q;
endmodule

// File: rtl/ddf_mode_ctrl.sv
module ddf_mode_ctrl
  import ddf_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [CFG_W-1:0]     wr_data,
  input  logic [NUM_START-1:0] start_in,
  input  logic                 data_rdy_in,
  output logic [RATE_W-1:0]    eff_rate,
  output logic [STG_W-1:0]     eff_stages,
  output logic [GROW_W-1:0]    eff_growth,
  output logic                 front_bypass,
  output logic                 front_stale,
  output logic                 fir_disable,
  output logic                 fir_abort,
  output logic                 acc_fb_zero,
  output logic                 data_rdy_out
);
  logic       rst_core_n;
  wr_strobe_t strobe;

  ddf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ddf_wr_decode u_dec (
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .strobe (strobe)
  );

  ddf_front_regs u_front (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_front1  (strobe.front1),
    .wr_front2  (strobe.front2),
    .rate_in    (wr_data[RATE_W-1:0]),
    .byp_in     (wr_data[BYP_BIT]),
    .stg_in     (wr_data[STG_LSB +: STG_W]),
    .grow_in    (wr_data[GRW_LSB +: GROW_W]),
    .eff_rate   (eff_rate),
    .eff_stages (eff_stages),
    .eff_growth (eff_growth),
    .bypass     (front_bypass),
    .stale      (front_stale)
  );

  ddf_fir_mode u_fir (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_fir     (strobe.fir),
    .dis_in     (wr_data[DIS_BIT]),
    .cla_in     (wr_data[CLA_BIT]),
    .start_in   (start_in),
    .rdy_in     (data_rdy_in),
    .disable_o  (fir_disable),
    .abort_o    (fir_abort),
    .acc_zero_o (acc_fb_zero),
    .rdy_out    (data_rdy_out)
  );
endmodule

// File: rtl/ddf_mode_ctrl_chk.sv
module ddf_mode_ctrl_chk
  import ddf_mode_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [1:0]           wr_sel,
  input logic [NUM_START-1:0] start_in,
  input logic [RATE_W-1:0]    eff_rate,
  input logic [STG_W-1:0]     eff_stages,
  input logic [GROW_W-1:0]    eff_growth,
  input logic                 front_bypass,
  input logic                 front_stale,
  input logic                 fir_disable,
  input logic                 fir_abort,
  input logic                 acc_fb_zero,
  input logic                 data_rdy_out
);
  // R3
  bypass_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    front_bypass |-> (eff_rate == '0 && eff_stages == '0 && eff_growth == GROW_W'(BYP_GROWTH)));

  // R5
  bypass_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    front_bypass |-> front_stale);

  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_in) |=> !fir_disable);

  // R8
  abort_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fir_abort |-> (fir_disable && !$past(fir_disable)));

  // R9
  rdy_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fb_zero |-> !data_rdy_out);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_sel == 2'b00) |=> ($stable(front_bypass) && $stable(acc_fb_zero) && $stable(front_stale)));
endmodule

bind ddf_mode_ctrl ddf_mode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .start_in     (start_in),
  .eff_rate     (eff_rate),
  .eff_stages   (eff_stages),
  .eff_growth   (eff_growth),
  .front_bypass (front_bypass),
  .front_stale  (front_stale),
  .fir_disable  (fir_disable),
  .fir_abort    (fir_abort),
  .acc_fb_zero  (acc_fb_zero),
  .data_rdy_out (data_rdy_out)
);

// File: tb/ddf_mode_ctrl_tb.sv
module ddf_mode_ctrl_tb;
  import ddf_mode_pkg::*;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 wr_en;
  logic [1:0]           wr_sel;
  logic [CFG_W-1:0]     wr_data;
  logic [NUM_START-1:0] start_in;
  logic                 data_rdy_in;
  logic [RATE_W-1:0]    eff_rate;
  logic [STG_W-1:0]     eff_stages;
  logic [GROW_W-1:0]    eff_growth;
  logic front_bypass, front_stale, fir_disable, fir_abort, acc_fb_zero, data_rdy_out;

  int n_vec = 0;
  int n_bad = 0;

  logic [RATE_W-1:0] m_rate;
  logic [STG_W-1:0]  m_stg;
  logic [GROW_W-1:0] m_grow;
  logic m_byp, m_stale, m_dis, m_cla, m_abt;

  always #2 clk = ~clk;

  ddf_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start_in(start_in), .data_rdy_in(data_rdy_in), .eff_rate(eff_rate),
    .eff_stages(eff_stages), .eff_growth(eff_growth), .front_bypass(front_bypass),
    .front_stale(front_stale), .fir_disable(fir_disable), .fir_abort(fir_abort),
    .acc_fb_zero(acc_fb_zero), .data_rdy_out(data_rdy_out)
  );

  task automatic compare(input string req);
    logic [RATE_W-1:0] x_rate;
    logic [STG_W-1:0]  x_stg;
    logic [GROW_W-1:0] x_grow;
    logic [24:0] act, exp;
    x_rate = m_byp ? '0 : m_rate;
    x_stg  = m_byp ? '0 : m_stg;
    x_grow = m_byp ? GROW_W'(50) : m_grow;
    exp = {x_rate, x_stg, x_grow, m_byp, m_stale, m_dis, m_abt, m_cla, data_rdy_in & ~m_cla};
    act = {eff_rate, eff_stages, eff_growth, front_bypass, front_stale, fir_disable,
           fir_abort, acc_fb_zero, data_rdy_out};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [1:0] sel, input logic [CFG_W-1:0] d,
                      input logic [NUM_START-1:0] st, input logic rdy, input string req);
    logic nd;
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d; start_in = st; data_rdy_in = rdy;
    nd = m_dis;
    if (en && sel == 2'b10) begin
      m_rate = d[9:0]; m_byp = d[10];
      if (d[10]) m_stale = 1'b1;
    end
    if (en && sel == 2'b11) begin
      m_stg = d[2:0]; m_grow = d[8:3];
      if (!m_byp) m_stale = 1'b0;
    end
    if (en && sel == 2'b01) begin
      nd = d[0]; m_cla = d[1];
    end
    if (st != '0) nd = 1'b0;
    m_abt = nd & ~m_dis;
    m_dis = nd;
    @(posedge clk);
    #1;
    compare(req);
  endtask

  initial begin
    #300000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; start_in = '0; data_rdy_in = 1'b0;
    m_rate = '0; m_stg = '0; m_grow = '0;
    m_byp = 0; m_stale = 0; m_dis = 0; m_cla = 0; m_abt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");

    // R2: full rate sweep with bypass clear
    for (int r = 0; r < 1024; r++) step(1, 2'b10, CFG_W'(r), '0, 0, "R2");
    // R4: every stage/growth pair
    for (int v = 0; v < 512; v++) step(1, 2'b11, CFG_W'(v), '0, 0, "R4");
    // R3: bypass overrides stored values
    step(1, 2'b10, CFG_W'(11'h400 | 11'd1023), '0, 0, "R3");
    step(1, 2'b10, CFG_W'(11'h400 | 11'd7), '0, 0, "R3");
    // R5: stale survives a rewrite during bypass and removal of bypass
    step(1, 2'b11, CFG_W'(9'h1AB), '0, 0, "R5");
    step(1, 2'b10, CFG_W'(11'd300), '0, 0, "R5");
    step(0, 2'b00, '0, '0, 0, "R5");
    step(1, 2'b11, CFG_W'(9'h0F5), '0, 0, "R5");
    // R10: idle and select-00 writes
    for (int k = 0; k < 8; k++) begin
      step(1, 2'b00, CFG_W'(k * 255), '0, 0, "R10");
      step(0, 2'(k), CFG_W'(~(k * 97)), '0, 0, "R10");
    end
    // R6, R7, R8: prior disable x write bits x start pattern
    for (int p = 0; p < 2; p++)
      for (int d = 0; d < 4; d++)
        for (int s = 0; s < 4; s++)
          for (int w = 0; w < 2; w++) begin
            step(1, 2'b01, CFG_W'(p), '0, 0, "R6");
            step(w[0], 2'b01, CFG_W'(d), NUM_START'(s), 0, "R7");
            step(0, 2'b00, '0, '0, 0, "R8");
          end
    // R9: data-ready gating
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 2; r++) begin
        step(1, 2'b01, CFG_W'(c << 1), '0, r[0], "R9");
        step(0, 2'b00, '0, '0, ~r[0], "R9");
      end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule